// File: doc/BRIEF.md
# Single-Cycle Instruction Control Decoder

This block turns one 32-bit instruction word into the control signals that steer a single-cycle load/store datapath. It is purely combinational: the outputs follow the instruction word in the same cycle, and nothing is stored. The decoder recognises register-type arithmetic (add, subtract, AND, OR, set-on-less-than), word load, word store, branch-if-equal and unconditional jump.

Decoding happens in two levels. A main decoder reads the 6-bit opcode from bits 31-26. It produces the datapath steering signals and a 2-bit ALU operation class. A second-level resolver combines that class with the function field in bits 5-0 and produces the 3-bit ALU select. For register-type words, only the low four bits of the function field take part in the match. The design has no states and no transitions. The house convention of one process for state and one for outputs becomes one combinational process per decoding level.

Top module: `ctrl_decode_unit`

## Requirements
- R1: Opcode 0 (register-type) drives wr_dst_rd=1 and reg_wr_en=1. alu_imm_sel, mem_rd_en, mem_wr_en, wb_from_mem, br_eq and jmp are all 0.
- R2: Opcode 35 (load) drives reg_wr_en, alu_imm_sel, mem_rd_en and wb_from_mem to 1 and every other control to 0. alu_sel is 3'b010 (add).
- R3: Opcode 43 (store) drives alu_imm_sel and mem_wr_en to 1 and every other control to 0, including reg_wr_en, wr_dst_rd and wb_from_mem. alu_sel is 3'b010.
- R4: Opcode 4 (branch-if-equal) drives br_eq to 1 and every other control to 0. alu_sel is 3'b110 (subtract).
- R5: Opcode 2 (jump) drives jmp to 1 and every other control to 0. alu_sel is 3'b010.
- R6: Any other opcode drives all eight controls to 0, so there is no register write, memory read or memory write. alu_sel is 3'b010.
- R7: For opcode 0, the low four bits of the function field select alu_sel as follows: 0000→010 (add), 0010→110 (subtract), 0100→000 (AND), 0101→001 (OR), 1010→111 (set-on-less-than). Function bits 5-4 have no effect.
- R8: For opcode 0, a function code whose low four bits are not listed in R7 gives alu_sel 3'b010.
- R9: For every opcode other than 0, bits 25-0 of the instruction (including the function field) have no effect on any output.
- R10: On every input, the outputs obey these rules: mem_rd_en and mem_wr_en are never both 1; wb_from_mem implies mem_rd_en; reg_wr_en is never 1 together with mem_wr_en, br_eq or jmp; br_eq implies alu_sel 3'b110.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_word | input | 32 | Instruction word to decode |
| wr_dst_rd | output | 1 | 1: destination is bits 15-11; 0: bits 20-16 |
| reg_wr_en | output | 1 | Register file write enable |
| alu_imm_sel | output | 1 | 1: second ALU operand is the sign-extended immediate |
| mem_rd_en | output | 1 | Data memory read enable |
| mem_wr_en | output | 1 | Data memory write enable |
| wb_from_mem | output | 1 | 1: write-back data comes from memory; 0: from the ALU |
| br_eq | output | 1 | Instruction is branch-if-equal |
| jmp | output | 1 | Instruction is an unconditional jump |
| alu_sel | output | 3 | ALU operation select |

## Verification
The assertions are evaluated whenever the inputs change. They cover the cross-signal rules of R10: the two memory enables never overlap, write-back from memory needs a memory read, register writes stay off for stores, branches and jumps, and a branch always selects subtract. They also check that the resolver's class input is never the unused value 11. Only the bench scenarios can show that each opcode gives its exact control vector. The same holds for the five function-code mappings and their don't-care upper bits, the fallback select for unlisted function codes and unsupported opcodes, and the fact that bits 25-0 are ignored outside register-type words.

// File: rtl/ctrl_decode_pkg.sv
package ctrl_decode_pkg;

    localparam int OPC_W     = 6;
    localparam int FN_W      = 6;
    localparam int ALU_SEL_W = 3;

    localparam logic [OPC_W-1:0] OPC_REG   = 6'd0;
    localparam logic [OPC_W-1:0] OPC_JUMP  = 6'd2;
    localparam logic [OPC_W-1:0] OPC_BEQ   = 6'd4;
    localparam logic [OPC_W-1:0] OPC_LOAD  = 6'd35;
    localparam logic [OPC_W-1:0] OPC_STORE = 6'd43;

    // operation class handed from main decoder to ALU resolver
    typedef enum logic [1:0] {
        CLS_ADD  = 2'b00,
        CLS_SUB  = 2'b01,
        CLS_FUNC = 2'b10
    } alu_cls_e;

    typedef enum logic [ALU_SEL_W-1:0] {
        ALU_AND = 3'b000,
        ALU_OR  = 3'b001,
        ALU_ADD = 3'b010,
        ALU_SUB = 3'b110,
        ALU_SLT = 3'b111
    } alu_sel_e;

    typedef struct packed {
        logic wr_dst_rd;
        logic reg_wr_en;
        logic alu_imm_sel;
        logic mem_rd_en;
        logic mem_wr_en;
        logic wb_from_mem;
        logic br_eq;
        logic jmp;
    } ctrl_s;

    localparam ctrl_s CTRL_NONE = '0;

endpackage

// File: rtl/instr_field_split.sv
module instr_field_split
    import ctrl_decode_pkg::*;
#(
    parameter int INSTR_W = 32,
    localparam int OPC_LSB = INSTR_W - OPC_W
) (
    input  logic [INSTR_W-1:0] instr,
    output logic [OPC_W-1:0]   opcode,
    output logic [FN_W-1:0]    funct
);

    assign opcode = instr[INSTR_W-1:OPC_LSB];
    assign funct  = instr[FN_W-1:0];

    // register numbers and immediates are consumed by the datapath, not here
    logic unused_mid_bits;
    assign unused_mid_bits = ^instr[OPC_LSB-1:FN_W];

endmodule

// File: rtl/ctrl_main_decode.sv
module ctrl_main_decode
    import ctrl_decode_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    output ctrl_s            ctrl,
    output alu_cls_e         cls,
    output logic             is_reg_type
);

    always_comb begin
        ctrl        = CTRL_NONE;
        cls         = CLS_ADD;
        is_reg_type = 1'b0;
        unique case (opcode)
            OPC_REG: begin
                ctrl.wr_dst_rd = 1'b1;
                ctrl.reg_wr_en = 1'b1;
                cls            = CLS_FUNC;
                is_reg_type    = 1'b1;
            end
            OPC_LOAD: begin
                ctrl.reg_wr_en   = 1'b1;
                ctrl.alu_imm_sel = 1'b1;
                ctrl.mem_rd_en   = 1'b1;
                ctrl.wb_from_mem = 1'b1;
            end
            OPC_STORE: begin
                ctrl.alu_imm_sel = 1'b1;
                ctrl.mem_wr_en   = 1'b1;
            end
            OPC_BEQ: begin
                ctrl.br_eq = 1'b1;
                cls        = CLS_SUB;
            end
            OPC_JUMP: begin
                ctrl.jmp = 1'b1;
            end
            default: begin
                ctrl = CTRL_NONE;
                cls  = CLS_ADD;
            end
        endcase
    end

    // R10: memory enables exclusive, write-back from memory needs a read
    always_comb begin
        p_mem_excl_r10: assert (!(ctrl.mem_rd_en && ctrl.mem_wr_en))
            else $error("memory read and write both enabled");
        p_wb_needs_rd_r10: assert (!ctrl.wb_from_mem || ctrl.mem_rd_en)
            else $error("write-back from memory without read");
    end

endmodule

// File: rtl/alu_op_resolve.sv
module alu_op_resolve
    import ctrl_decode_pkg::*;
#(
    parameter int FN_KEY_W = 4
) (
    input  alu_cls_e          cls,
    input  logic [FN_W-1:0]   funct,
    output alu_sel_e          sel
);

    logic [FN_KEY_W-1:0] key;
    assign key = funct[FN_KEY_W-1:0];

    logic unused_fn_hi;
    assign unused_fn_hi = ^funct[FN_W-1:FN_KEY_W];

    alu_sel_e fn_sel;

    always_comb begin
        case (key)
            4'b0000: fn_sel = ALU_ADD;
            4'b0010: fn_sel = ALU_SUB;
            4'b0100: fn_sel = ALU_AND;
            4'b0101: fn_sel = ALU_OR;
            4'b1010: fn_sel = ALU_SLT;
            default: fn_sel = ALU_ADD;
        endcase
    end

    // class bit 0 (subtract) takes precedence over bit 1 (function field)
    always_comb begin
        if (cls[0])
            sel = ALU_SUB;
        else if (cls[1])
            sel = fn_sel;
        else
            sel = ALU_ADD;
    end

    always_comb begin
        p_cls_legal_r10: assert (cls != alu_cls_e'(2'b11))
            else $error("illegal operation class");
    end

endmodule

// File: rtl/ctrl_decode_unit.sv
module ctrl_decode_unit
    import ctrl_decode_pkg::*;
#(
    parameter int INSTR_W  = 32,
    parameter int FN_KEY_W = 4
) (
    input  logic [INSTR_W-1:0]   instr_word,
    output logic                 wr_dst_rd,
    output logic                 reg_wr_en,
    output logic                 alu_imm_sel,
    output logic                 mem_rd_en,
    output logic                 mem_wr_en,
    output logic                 wb_from_mem,
    output logic                 br_eq,
    output logic                 jmp,
    output logic [ALU_SEL_W-1:0] alu_sel
);

    logic [OPC_W-1:0] opcode;
    logic [FN_W-1:0]  funct;
    ctrl_s            ctrl;
    alu_cls_e         cls;
    alu_sel_e         sel;
    logic             is_reg_type;

    instr_field_split #(.INSTR_W(INSTR_W)) u_split (
        .instr  (instr_word),
        .opcode (opcode),
        .funct  (funct)
    );

    ctrl_main_decode u_main (
        .opcode      (opcode),
        .ctrl        (ctrl),
        .cls         (cls),
        .is_reg_type (is_reg_type)
    );

    alu_op_resolve #(.FN_KEY_W(FN_KEY_W)) u_alu (
        .cls   (cls),
        .funct (funct),
        .sel   (sel)
    );

    assign wr_dst_rd   = ctrl.wr_dst_rd;
    assign reg_wr_en   = ctrl.reg_wr_en;
    assign alu_imm_sel = ctrl.alu_imm_sel;
    assign mem_rd_en   = ctrl.mem_rd_en;
    assign mem_wr_en   = ctrl.mem_wr_en;
    assign wb_from_mem = ctrl.wb_from_mem;
    assign br_eq       = ctrl.br_eq;
    assign jmp         = ctrl.jmp;
    assign alu_sel     = sel;

    // R10: cross-level rules between main decoder and ALU resolver
    always_comb begin
        p_no_wr_on_store_r10: assert (!(reg_wr_en && mem_wr_en))
            else $error("register write during store");
        p_no_wr_on_flow_r10: assert (!(reg_wr_en && (br_eq || jmp)))
            else $error("register write during branch or jump");
        p_branch_sub_r10: assert (!br_eq || alu_sel == 3'b110)
            else $error("branch without subtract");
        p_rdst_regtype_r1: assert (!wr_dst_rd || is_reg_type)
            else $error("rd destination outside register-type");
    end

endmodule

// File: tb/ctrl_decode_unit_test.sv
module ctrl_decode_unit_test;

    logic        clk = 1'b0;
    logic [31:0] instr_word = '0;
    logic        wr_dst_rd, reg_wr_en, alu_imm_sel, mem_rd_en;
    logic        mem_wr_en, wb_from_mem, br_eq, jmp;
    logic [2:0]  alu_sel;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    ctrl_decode_unit uut (
        .instr_word  (instr_word),
        .wr_dst_rd   (wr_dst_rd),
        .reg_wr_en   (reg_wr_en),
        .alu_imm_sel (alu_imm_sel),
        .mem_rd_en   (mem_rd_en),
        .mem_wr_en   (mem_wr_en),
        .wb_from_mem (wb_from_mem),
        .br_eq       (br_eq),
        .jmp         (jmp),
        .alu_sel     (alu_sel)
    );

    // packed: {dst,rw,imm,mrd,mwr,wbm,br,j,alu[2:0]}
    function automatic logic [10:0] outs();
        return {wr_dst_rd, reg_wr_en, alu_imm_sel, mem_rd_en, mem_wr_en,
                wb_from_mem, br_eq, jmp, alu_sel};
    endfunction

    function automatic logic [2:0] fn_expect(input logic [5:0] f);
        case (f[3:0])
            4'b0000: return 3'b010;
            4'b0010: return 3'b110;
            4'b0100: return 3'b000;
            4'b0101: return 3'b001;
            4'b1010: return 3'b111;
            default: return 3'b010;
        endcase
    endfunction

    function automatic logic [10:0] expect_of(input logic [31:0] w);
        case (w[31:26])
            6'd0:    return {8'b1100_0000, fn_expect(w[5:0])};
            6'd35:   return {8'b0111_0100, 3'b010};
            6'd43:   return {8'b0010_1000, 3'b010};
            6'd4:    return {8'b0000_0010, 3'b110};
            6'd2:    return {8'b0000_0001, 3'b010};
            default: return {8'b0000_0000, 3'b010};
        endcase
    endfunction

    task automatic apply_check(input logic [31:0] w, input logic [10:0] exp_v,
                               input string req);
        @(negedge clk);
        instr_word = w;
        @(posedge clk);
        #1;
        n_checks++;
        if (outs() !== exp_v) begin
            n_fails++;
            $display("FAIL %s instr=%h actual=%b expected=%b", req, w, outs(), exp_v);
        end
    endtask

    task automatic t_initial;   // R1: all-zero word is register-type add
        apply_check(32'h0000_0000, {8'b1100_0000, 3'b010}, "R1");
    endtask

    task automatic t_reg_type;  // R1 R7 R8
        apply_check({6'd0, 5'd2, 5'd3, 5'd4, 5'd0, 6'b100000}, {8'b1100_0000, 3'b010}, "R7 add");
        apply_check({6'd0, 5'd2, 5'd3, 5'd4, 5'd0, 6'b100010}, {8'b1100_0000, 3'b110}, "R7 sub");
        apply_check({6'd0, 5'd2, 5'd3, 5'd4, 5'd0, 6'b100100}, {8'b1100_0000, 3'b000}, "R7 and");
        apply_check({6'd0, 5'd2, 5'd3, 5'd4, 5'd0, 6'b100101}, {8'b1100_0000, 3'b001}, "R7 or");
        apply_check({6'd0, 5'd2, 5'd3, 5'd4, 5'd0, 6'b101010}, {8'b1100_0000, 3'b111}, "R7 slt");
        apply_check({6'd0, 20'hABCDE, 6'b011010}, {8'b1100_0000, 3'b111}, "R7 upper bits ignored");
        apply_check({6'd0, 20'h0, 6'b110101}, {8'b1100_0000, 3'b001}, "R7 upper bits ignored");
        apply_check({6'd0, 20'h0, 6'b100111}, {8'b1100_0000, 3'b010}, "R8 unlisted funct");
        apply_check({6'd0, 20'h0, 6'b001111}, {8'b1100_0000, 3'b010}, "R8 unlisted funct");
        for (int f = 0; f < 64; f++)
            apply_check({6'd0, 20'h5A5A5, 6'(f)}, {8'b1100_0000, fn_expect(6'(f))}, "R1 R7 R8 sweep");
    endtask

    task automatic t_load;
        apply_check({6'd35, 5'd9, 5'd8, 16'hFFFC}, {8'b0111_0100, 3'b010}, "R2 load");
    endtask

    task automatic t_store;
        apply_check({6'd43, 5'd9, 5'd8, 16'h0010}, {8'b0010_1000, 3'b010}, "R3 store");
    endtask

    task automatic t_branch;
        apply_check({6'd4, 5'd1, 5'd2, 16'h8000}, {8'b0000_0010, 3'b110}, "R4 branch");
    endtask

    task automatic t_jump;
        apply_check({6'd2, 26'h3FF_FFFF}, {8'b0000_0001, 3'b010}, "R5 jump");
    endtask

    task automatic t_unsupported;   // R6 sweep of every opcode
        for (int op = 0; op < 64; op++)
            apply_check({6'(op), 26'h0}, expect_of({6'(op), 26'h0}), "R6 opcode sweep");
        apply_check({6'd63, 26'h000_0022}, {8'b0000_0000, 3'b010}, "R6 unsupported");
    endtask

    task automatic t_field_ignore;  // R9: bits 25-0 irrelevant outside opcode 0
        logic [31:0] lfsr = 32'hACE1_2468;
        for (int i = 0; i < 200; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            if (lfsr[31:26] != 6'd0)
                apply_check(lfsr, expect_of({lfsr[31:26], 26'h0}), "R9 field ignore");
        end
        apply_check({6'd35, 20'h0, 6'b101010}, {8'b0111_0100, 3'b010}, "R9 load funct ignored");
        apply_check({6'd4, 20'hFFFFF, 6'b100100}, {8'b0000_0010, 3'b110}, "R9 branch funct ignored");
    endtask

    task automatic t_rules;  // R10 checked at the ports on a mixed sequence
        logic [31:0] seq [6];
        seq = '{32'h0, {6'd35, 26'h1}, {6'd43, 26'h2}, {6'd4, 26'h3}, {6'd2, 26'h4}, {6'd17, 26'h5}};
        foreach (seq[i]) begin
            @(negedge clk);
            instr_word = seq[i];
            @(posedge clk);
            #1;
            n_checks++;
            if ((mem_rd_en && mem_wr_en) || (wb_from_mem && !mem_rd_en) ||
                (reg_wr_en && (mem_wr_en || br_eq || jmp)) ||
                (br_eq && alu_sel != 3'b110)) begin
                n_fails++;
                $display("FAIL R10 instr=%h actual=%b expected=rules hold", seq[i], outs());
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        t_initial();
        t_reg_type();
        t_load();
        t_store();
        t_branch();
        t_jump();
        t_unsupported();
        t_field_ignore();
        t_rules();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule